// File: doc/BRIEF.md
# EEPROM Serial Pin Control Port

This block gives host software direct, bit-level control over a serial three-wire EEPROM (chip select, serial clock, serial data in, plus the EEPROM's data-out line). Software writes a small control word holding an enable flag, a chip-select bit, a clock bit and a data bit. It then steps the serial protocol by rewriting that word, one edge at a time. Reads of the same word return the control bits and the live EEPROM data-out level. The data-out level first passes through a synchronizer.

Writes are accepted only while the surrounding controller reports that it is halted or suspended, so software cannot disturb the EEPROM during normal operation. Ownership of the three EEPROM pins moves between three sources. The reset pin has the highest priority: while it is high the clock and data drivers are released and chip select is held low. An automatic read engine outside the block comes next, and software comes last. When software owns the pins but has left the enable flag clear, all three are driven low.

Top module: `eeprom_pinctl`

## Requirements
- R1: After a hard reset (`rst`), the control word reads back with enable=0, chip select=0 and clock=1, and the stored data-out control bit is 0.
- R2: A write strobe (`reg_wr`) changes the control word only when `halt_i` or `susp_i` is high in the same cycle; otherwise the readback and the pins stay as they were.
- R3: `soft_rst` leaves every control bit unchanged, and a write strobe in the same cycle as `soft_rst` is dropped.
- R4: Read layout: bit 3 is enable, bit 2 is chip select, bit 1 is clock, and bit 0 is the `ee_do` input after `SYNC_STAGES` clock edges, never the written data bit.
- R5: While `rst` is high, `pin_sk_oe` and `pin_di_oe` are 0 and `pin_cs` is 0, whatever the other inputs are.
- R6: While `aread_busy` is high and `rst` is low, `pin_cs`, `pin_sk` and `pin_di` equal `aread_cs`, `aread_sk` and `aread_di`, both enables are 1, and the control bits have no effect on the pins.
- R7: With enable=1, `aread_busy` low and `rst` low, `pin_cs`, `pin_sk` and `pin_di` follow control bits 2, 1 and 0. A change takes effect on the clock edge that accepts the write.
- R8: With enable=0, `aread_busy` low and `rst` low, `pin_cs`, `pin_sk` and `pin_di` are 0 and both enables are 1.
- R9: A write accepted while `aread_busy` is high is stored, and it drives the pins once `aread_busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hard reset, synchronous, active high; also forces pins to the reset state |
| soft_rst | input | 1 | Soft reset; preserves control bits and blocks a same-cycle write |
| halt_i | input | 1 | Controller halted status, enables writes |
| susp_i | input | 1 | Controller suspended status, enables writes |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_wdata | input | 4 | Write data {enable, cs, clock, data} |
| reg_rdata | output | 4 | Read data {enable, cs, clock, synchronized ee_do} |
| aread_busy | input | 1 | Automatic read engine owns the pins |
| aread_cs | input | 1 | Chip-select value from the read engine |
| aread_sk | input | 1 | Clock value from the read engine |
| aread_di | input | 1 | Data value from the read engine |
| ee_do | input | 1 | EEPROM serial data output |
| pin_cs | output | 1 | EEPROM chip select |
| pin_sk | output | 1 | EEPROM serial clock |
| pin_sk_oe | output | 1 | Output enable for `pin_sk` |
| pin_di | output | 1 | EEPROM serial data input |
| pin_di_oe | output | 1 | Output enable for `pin_di` |

## Verification
The bench uses the default `SYNC_STAGES` of 2. This lets it count exactly when a change on `ee_do` reaches read bit 0: the bit stays at its old value after the first edge and takes the new value after the second. The fixed four-bit control word makes every combination of enable, owner and status gating reachable from a short vector table. Directed cases then cover reset arriving while software or the read engine holds the pins.

// File: rtl/eeprom_pinctl_pkg.sv
package eeprom_pinctl_pkg;

    localparam int CTL_W  = 4;
    localparam int DO_POS = 0;
    localparam int SK_POS = 1;
    localparam int CS_POS = 2;
    localparam int EN_POS = 3;

    // Field order matches the bit positions above (en is the MSB)
    typedef struct packed {
        logic en;
        logic cs;
        logic sk;
        logic dout;
    } ctl_t;

    typedef struct packed {
        logic cs;
        logic sk;
        logic sk_oe;
        logic di;
        logic di_oe;
    } pins_t;

    typedef enum logic [1:0] {
        OWN_RESET = 2'd0,
        OWN_AUTO  = 2'd1,
        OWN_SW    = 2'd2,
        OWN_IDLE  = 2'd3
    } owner_e;

    localparam ctl_t CTL_RST = '{en: 1'b0, cs: 1'b0, sk: 1'b1, dout: 1'b0};

    function automatic owner_e pick_owner(input logic rst, input logic busy,
                                          input logic en);
        if (rst)       return OWN_RESET;
        else if (busy) return OWN_AUTO;
        else if (en)   return OWN_SW;
        else           return OWN_IDLE;
    endfunction

    function automatic ctl_t unpack_ctl(input logic [CTL_W-1:0] w);
        ctl_t c;
        c.en   = w[EN_POS];
        c.cs   = w[CS_POS];
        c.sk   = w[SK_POS];
        c.dout = w[DO_POS];
        return c;
    endfunction

endpackage

// File: rtl/eeprom_pinctl_regs.sv
module eeprom_pinctl_regs
    import eeprom_pinctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic halt_i,
    input  logic susp_i,
    input  logic wr,
    input  ctl_t wdata,
    output ctl_t q
);
    logic wr_ok;

    // Writes only in the halted/suspended window; soft reset wins over a write
    assign wr_ok = wr && (halt_i || susp_i) && !soft_rst;

    always_ff @(posedge clk) begin
        if (rst)        q <= CTL_RST;
        else if (wr_ok) q <= wdata;
    end
endmodule

// File: rtl/eeprom_pinctl_sync.sv
module eeprom_pinctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/eeprom_pinctl_mux.sv
module eeprom_pinctl_mux
    import eeprom_pinctl_pkg::*;
(
    input  logic  rst,
    input  logic  busy,
    input  ctl_t  sw,
    input  logic  a_cs,
    input  logic  a_sk,
    input  logic  a_di,
    output pins_t pins,
    output owner_e owner
);
    always_comb begin
        owner = pick_owner(rst, busy, sw.en);
        pins  = '0;
        unique case (owner)
            OWN_RESET: pins = '{cs: 1'b0, sk: 1'b0, sk_oe: 1'b0, di: 1'b0, di_oe: 1'b0};
            OWN_AUTO:  pins = '{cs: a_cs, sk: a_sk, sk_oe: 1'b1, di: a_di, di_oe: 1'b1};
            OWN_SW:    pins = '{cs: sw.cs, sk: sw.sk, sk_oe: 1'b1, di: sw.dout, di_oe: 1'b1};
            OWN_IDLE:  pins = '{cs: 1'b0, sk: 1'b0, sk_oe: 1'b1, di: 1'b0, di_oe: 1'b1};
            default:   pins = '0;
        endcase
    end
endmodule

// File: rtl/eeprom_pinctl.sv
module eeprom_pinctl
    import eeprom_pinctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             halt_i,
    input  logic             susp_i,
    input  logic             reg_wr,
    input  logic [CTL_W-1:0] reg_wdata,
    output logic [CTL_W-1:0] reg_rdata,
    input  logic             aread_busy,
    input  logic             aread_cs,
    input  logic             aread_sk,
    input  logic             aread_di,
    input  logic             ee_do,
    output logic             pin_cs,
    output logic             pin_sk,
    output logic             pin_sk_oe,
    output logic             pin_di,
    output logic             pin_di_oe
);
    ctl_t   ctl_q;
    pins_t  pins;
    owner_e owner;
    logic   do_sync;

    eeprom_pinctl_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .halt_i   (halt_i),
        .susp_i   (susp_i),
        .wr       (reg_wr),
        .wdata    (unpack_ctl(reg_wdata)),
        .q        (ctl_q)
    );

    eeprom_pinctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ee_do),
        .q   (do_sync)
    );

    eeprom_pinctl_mux u_mux (
        .rst   (rst),
        .busy  (aread_busy),
        .sw    (ctl_q),
        .a_cs  (aread_cs),
        .a_sk  (aread_sk),
        .a_di  (aread_di),
        .pins  (pins),
        .owner (owner)
    );

    always_comb begin
        reg_rdata         = '0;
        reg_rdata[EN_POS] = ctl_q.en;
        reg_rdata[CS_POS] = ctl_q.cs;
        reg_rdata[SK_POS] = ctl_q.sk;
        reg_rdata[DO_POS] = do_sync;
    end

    assign pin_cs    = pins.cs;
    assign pin_sk    = pins.sk;
    assign pin_sk_oe = pins.sk_oe;
    assign pin_di    = pins.di;
    assign pin_di_oe = pins.di_oe;

    logic owner_unused;
    assign owner_unused = ^owner;
endmodule

// File: rtl/eeprom_pinctl_chk.sv
module eeprom_pinctl_chk
    import eeprom_pinctl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             soft_rst,
    input logic             halt_i,
    input logic             susp_i,
    input logic             reg_wr,
    input logic [CTL_W-1:0] reg_rdata,
    input logic             aread_busy,
    input logic             aread_cs,
    input logic             aread_sk,
    input logic             aread_di,
    input logic             pin_cs,
    input logic             pin_sk,
    input logic             pin_sk_oe,
    input logic             pin_di,
    input logic             pin_di_oe,
    input ctl_t             ctl_q
);
    AST_RESET_VALUE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ctl_q == CTL_RST); // R1

    AST_WRITE_GATED: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !halt_i && !susp_i) |=> $stable(reg_rdata[CTL_W-1:1])); // R2

    AST_SOFT_KEEPS: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> $stable(ctl_q)); // R3

    always @(negedge clk) begin
        if (rst) begin
            AST_RESET_PINS: assert (!pin_sk_oe && !pin_di_oe && !pin_cs); // R5
        end
    end

    AST_AUTO_OWNS: assert property (@(posedge clk) disable iff (rst)
        aread_busy |-> (pin_cs == aread_cs && pin_sk == aread_sk &&
                        pin_di == aread_di && pin_sk_oe && pin_di_oe)); // R6

    AST_SW_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (!aread_busy && reg_rdata[EN_POS]) |->
            (pin_cs == reg_rdata[CS_POS] && pin_sk == reg_rdata[SK_POS] &&
             pin_di == ctl_q.dout)); // R7

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        (!aread_busy && !reg_rdata[EN_POS]) |->
            (!pin_cs && !pin_sk && !pin_di && pin_sk_oe && pin_di_oe)); // R8
endmodule

bind eeprom_pinctl eeprom_pinctl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .soft_rst   (soft_rst),
    .halt_i     (halt_i),
    .susp_i     (susp_i),
    .reg_wr     (reg_wr),
    .reg_rdata  (reg_rdata),
    .aread_busy (aread_busy),
    .aread_cs   (aread_cs),
    .aread_sk   (aread_sk),
    .aread_di   (aread_di),
    .pin_cs     (pin_cs),
    .pin_sk     (pin_sk),
    .pin_sk_oe  (pin_sk_oe),
    .pin_di     (pin_di),
    .pin_di_oe  (pin_di_oe),
    .ctl_q      (ctl_q)
);

// File: tb/eeprom_pinctl_bench.sv
module eeprom_pinctl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       soft_rst = 1'b0;
    logic       halt_i = 1'b0;
    logic       susp_i = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_wdata = 4'h0;
    logic [3:0] reg_rdata;
    logic       aread_busy = 1'b0;
    logic       aread_cs = 1'b1;
    logic       aread_sk = 1'b0;
    logic       aread_di = 1'b1;
    logic       ee_do = 1'b0;
    logic       pin_cs, pin_sk, pin_sk_oe, pin_di, pin_di_oe;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    eeprom_pinctl u_eeprom_pinctl (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .halt_i(halt_i), .susp_i(susp_i),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .aread_busy(aread_busy), .aread_cs(aread_cs), .aread_sk(aread_sk),
        .aread_di(aread_di), .ee_do(ee_do), .pin_cs(pin_cs), .pin_sk(pin_sk),
        .pin_sk_oe(pin_sk_oe), .pin_di(pin_di), .pin_di_oe(pin_di_oe)
    );

    // {halt, susp, busy, wr, wdata[3:0] = {en,cs,sk,d}, pins {cs,sk,di}, rd {en,cs,sk}}
    localparam logic [13:0] VEC [8] = '{
        {4'b0001, 4'b1111, 3'b000, 3'b001},  // R2 blocked, R8 idle low
        {4'b1001, 4'b1111, 3'b111, 3'b111},  // R7 software drives
        {4'b0101, 4'b1010, 3'b010, 3'b101},  // R7 via suspend
        {4'b0001, 4'b0000, 3'b010, 3'b101},  // R2 blocked again
        {4'b1011, 4'b1101, 3'b101, 3'b110},  // R6 engine owns, R9 stored
        {4'b0000, 4'b0000, 3'b101, 3'b110},  // R9 stored value now drives
        {4'b1001, 4'b0110, 3'b000, 3'b011},  // R8 disabled
        {4'b1101, 4'b1001, 3'b001, 3'b100}   // R7 both status bits
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] pins3();
        return {pin_cs, pin_sk, pin_di};
    endfunction

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R5 reset oe/cs", {5'b0, pin_sk_oe, pin_di_oe, pin_cs}, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset readback", {5'b0, reg_rdata[3:1]}, 8'h01);
        check("R8 idle after reset", {3'b0, pin_sk_oe, pin_di_oe, pins3()}, 8'h18);

        foreach (VEC[i]) begin
            @(negedge clk);
            {halt_i, susp_i, aread_busy, reg_wr} = VEC[i][13:10];
            reg_wdata = VEC[i][9:6];
            @(negedge clk);
            reg_wr = 1'b0;
            check($sformatf("R2/R6/R7/R8/R9 vec%0d pins", i), {5'b0, pins3()}, {5'b0, VEC[i][5:3]});
            check($sformatf("R2/R7/R9 vec%0d readback", i), {5'b0, reg_rdata[3:1]}, {5'b0, VEC[i][2:0]});
        end
        halt_i = 1'b0; susp_i = 1'b0; aread_busy = 1'b0;

        // R4: data bit reads the synchronized input, not the written bit (last write d=1)
        @(negedge clk);
        check("R4 data bit not written value", {7'b0, reg_rdata[0]}, 8'h00);
        ee_do = 1'b1;
        @(negedge clk);
        check("R4 after one edge", {7'b0, reg_rdata[0]}, 8'h00);
        @(negedge clk);
        check("R4 after two edges", {7'b0, reg_rdata[0]}, 8'h01);
        ee_do = 1'b0;

        // R3: soft reset keeps bits and drops a simultaneous write
        halt_i = 1'b1; soft_rst = 1'b1; reg_wr = 1'b1; reg_wdata = 4'b0110;
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
        soft_rst = 1'b0;
        check("R3 soft reset readback", {5'b0, reg_rdata[3:1]}, 8'h04);
        check("R3 soft reset pins", {5'b0, pins3()}, 8'h01);

        // R5: reset arrives while software drives, then while the engine is busy
        reg_wr = 1'b1; reg_wdata = 4'b1111;
        @(negedge clk);
        reg_wr = 1'b0;
        check("R7 pins before reset", {5'b0, pins3()}, 8'h07);
        rst = 1'b1;
        #1;
        check("R5 reset over software", {5'b0, pin_sk_oe, pin_di_oe, pin_cs}, 8'h00);
        aread_busy = 1'b1;
        #1;
        check("R5 reset over engine", {5'b0, pin_sk_oe, pin_di_oe, pin_cs}, 8'h00);
        @(negedge clk);
        aread_busy = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R1 readback after second reset", {5'b0, reg_rdata[3:1]}, 8'h01);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule